// File: doc/BRIEF.md
# Six-Pin Bidirectional Port Controller

This block is a small general-purpose I/O port that sits on a simple register bus of a microcontroller-style core. Software programs a direction mask, an output value, an analog-select mask, per-pin pull-up enables and a single global pull-up switch. The block turns these settings into three control vectors for the tri-state pads: the value to drive, the driver enable and the weak pull-up enable.

A read of the port register returns the levels seen on the pads, after a synchronizer. It does not return the output latch. Pins marked analog read as zero, and the input-only pin can also be masked out by a configuration input that hands it over to the reset function. That pin is never driven and never gets a pull-up. Its direction bit always reads as input.

The bus uses single-cycle write and read strobes. The read data becomes valid, together with a valid flag, one clock after the read strobe.

Top module: `gpioPort`

## Requirements
- R1: After reset every direction bit reads 1 (direction register reads 0x3F), padOe and padPullUp are all zero, padOut is zero, and the global control register reads 0x01 (bit 0 = pull-ups off).
- R2: A pin whose direction bit is 0 has its padOe bit set and padOut carries the output latch bit. A pin whose direction bit is 1 has padOe clear.
- R3: Pin 3 is input only. Its padOe bit is never set and its direction bit reads 1 whatever value was written to it.
- R4: A write to offset 0 loads the output latch from bits 5:0 of the write data. A read of offset 0 returns the pad levels after two synchronizer flops, not the latch, with bits 7:6 reading 0.
- R5: While resetPinEn is 1, bit 3 of a port read is 0.
- R6: A pin set to 1 in the analog-select register (offset 2) reads 0 in the port register. Its driver is still controlled by its direction bit.
- R7: padPullUp for pin i equals (global control bit 0 is 0) AND (pull-up enable bit i at offset 3) AND (direction bit i is 1), and is always 0 for pin 3.
- R8: busRdValid is 1 in the cycle after a cycle with busRdEn high and 0 otherwise. Offsets 5, 6 and 7 read 0x00.
- R9: The direction (offset 1), analog-select (offset 2), pull-up enable (offset 3, bit 3 always 0) and global control (offset 4, bit 0 only) registers read back what was written. Unimplemented bits read 0. The pull-up enables reset to 0x37 and the analog select resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| resetPinEn | input | 1 | Configuration: pin 3 serves as the reset pin |
| padIn | input | 6 | Pad input levels |
| padOut | output | 6 | Pad output values |
| padOe | output | 6 | Pad driver enables |
| padPullUp | output | 6 | Pad weak pull-up enables |

## Verification
The bench builds the block with its defaults: six pins, pin 3 as the input-only pin and a two-flop synchronizer. With a 6-bit mask, random direction, analog, pull-up and pad patterns reach every mix of pin roles within a few dozen iterations. Because the port is narrower than the 8-bit bus, the bench also covers the always-zero upper bits. The short synchronizer keeps the wait between a pad change and the read that must see it to three cycles. That wait applies to every pad pattern, including one where pin 3 is both high on the pad and claimed by the reset configuration.

// File: rtl/gpioPkg.sv
package gpioPkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 3'd0,
    REG_DIR  = 3'd1,
    REG_ANA  = 3'd2,
    REG_PULL = 3'd3,
    REG_CTL  = 3'd4
  } regSel_e;

  typedef struct packed {
    logic              wrPort;
    logic              wrDir;
    logic              wrAna;
    logic              wrPull;
    logic              wrCtl;
    logic              rdEn;
    logic [ADDR_W-1:0] sel;
  } busStrobe_t;
endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpioPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busStrobe_t        strobe,
  output logic              rdValid
);

  always_comb begin
    strobe.wrPort = busWrEn && (busAddr == REG_PORT);
    strobe.wrDir  = busWrEn && (busAddr == REG_DIR);
    strobe.wrAna  = busWrEn && (busAddr == REG_ANA);
    strobe.wrPull = busWrEn && (busAddr == REG_PULL);
    strobe.wrCtl  = busWrEn && (busAddr == REG_CTL);
    strobe.rdEn   = busRdEn;
    strobe.sel    = busAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= busRdEn;
  end

  // R8
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> rdValid);

  // R8
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !rdValid);

endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPkg::*;
#(
  parameter int PORT_W         = 6,
  parameter int INPUT_ONLY_PIN = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              resetPinEn,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padPullUp,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [PORT_W-1:0] PIN_BIT   = PORT_W'(1) << INPUT_ONLY_PIN;
  localparam logic [PORT_W-1:0] DRIVE_MSK = ~PIN_BIT;
  localparam int                PAD_W     = DATA_W - PORT_W;

  logic [PORT_W-1:0] latchQ;
  logic [PORT_W-1:0] dirQ;
  logic [PORT_W-1:0] anaQ;
  logic [PORT_W-1:0] pullEnQ;
  logic              pullOffQ;
  logic [PORT_W-1:0] syncQ [SYNC_STAGES];
  logic [PORT_W-1:0] pinLevel;
  logic [PORT_W-1:0] portView;
  logic [DATA_W-1:0] rdNext;
  logic              unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:PORT_W];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ   <= '0;
      dirQ     <= '1;
      anaQ     <= '0;
      pullEnQ  <= DRIVE_MSK;
      pullOffQ <= 1'b1;
    end else begin
      if (strobe.wrPort) latchQ   <= wrData[PORT_W-1:0];
      if (strobe.wrDir)  dirQ     <= wrData[PORT_W-1:0] | PIN_BIT;
      if (strobe.wrAna)  anaQ     <= wrData[PORT_W-1:0];
      if (strobe.wrPull) pullEnQ  <= wrData[PORT_W-1:0] & DRIVE_MSK;
      if (strobe.wrCtl)  pullOffQ <= wrData[0];
    end
  end

  // Pad input synchronizer
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= '0;
          else       syncQ[0] <= padIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign pinLevel = syncQ[SYNC_STAGES-1];

  // Pad controls
  always_comb begin
    padOut    = latchQ;
    padOe     = ~dirQ & DRIVE_MSK;
    padPullUp = {PORT_W{~pullOffQ}} & pullEnQ & dirQ & DRIVE_MSK;
  end

  // Port view: digital pin levels with analog and reset-pin masking
  always_comb begin
    portView = pinLevel & ~anaQ;
    if (resetPinEn) portView = portView & ~PIN_BIT;
  end

  // Read multiplexer
  always_comb begin
    rdNext = '0;
    case (strobe.sel)
      REG_PORT: rdNext = {{PAD_W{1'b0}}, portView};
      REG_DIR:  rdNext = {{PAD_W{1'b0}}, dirQ};
      REG_ANA:  rdNext = {{PAD_W{1'b0}}, anaQ};
      REG_PULL: rdNext = {{PAD_W{1'b0}}, pullEnQ};
      REG_CTL:  rdNext = {{(DATA_W-1){1'b0}}, pullOffQ};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= rdNext;
  end

  // R4
  latch_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrPort |=> padOut == $past(wrData[PORT_W-1:0]));

  // R3
  input_pin_dir_reads_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.sel == REG_DIR) |=> rdData[INPUT_ONLY_PIN]);

  // R7
  no_pull_on_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padOe) == '0);

  // R6
  analog_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.sel == REG_PORT) |=> (rdData[PORT_W-1:0] & $past(anaQ)) == '0);

  // R5
  reset_pin_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.sel == REG_PORT && resetPinEn) |=> !rdData[INPUT_ONLY_PIN]);

  // R8
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.sel > REG_CTL) |=> rdData == '0);

endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpioPkg::*;
#(
  parameter int PORT_W         = 6,
  parameter int INPUT_ONLY_PIN = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdValid,
  input  logic              resetPinEn,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padPullUp
);

  busStrobe_t strobe;

  gpioCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe),
    .rdValid (busRdValid)
  );

  gpioDatapath #(
    .PORT_W         (PORT_W),
    .INPUT_ONLY_PIN (INPUT_ONLY_PIN),
    .SYNC_STAGES    (SYNC_STAGES)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (busWrData),
    .resetPinEn (resetPinEn),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .padPullUp  (padPullUp),
    .rdData     (busRdData)
  );

endmodule

// File: tb/test_gpioPort.sv
module test_gpioPort;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       busRdValid;
  logic       resetPinEn = 1'b0;
  logic [5:0] padIn = '0;
  logic [5:0] padOut;
  logic [5:0] padOe;
  logic [5:0] padPullUp;

  int checks = 0;
  int errors = 0;

  // Bench model of the programmed registers
  logic [5:0] mLatch, mDir, mAna, mPull;
  logic       mOff;

  always #5 clk = ~clk;

  gpioPort i_gpioPort (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .resetPinEn(resetPinEn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp)
  );

  function automatic logic [7:0] expPortRead(logic [5:0] pins, logic [5:0] ana, logic rpe);
    logic [5:0] v;
    v = pins & ~ana;
    if (rpe) v[3] = 1'b0;
    return {2'b00, v};
  endfunction

  function automatic logic [5:0] expOe(logic [5:0] dir);
    return ~dir & 6'h37;
  endfunction

  function automatic logic [5:0] expPullUp(logic off, logic [5:0] en, logic [5:0] dir);
    return off ? 6'h00 : (en & dir & 6'h37);
  endfunction

  function automatic logic [7:0] expReg(logic [2:0] a);
    case (a)
      3'd1: return {2'b00, mDir};
      3'd2: return {2'b00, mAna};
      3'd3: return {2'b00, mPull};
      3'd4: return {7'b0, mOff};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic modelReset();
    mLatch = '0; mDir = 6'h3F; mAna = '0; mPull = 6'h37; mOff = 1'b1;
  endtask

  task automatic busWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    case (a)
      3'd0: mLatch = d[5:0];
      3'd1: mDir   = d[5:0] | 6'h08;
      3'd2: mAna   = d[5:0];
      3'd3: mPull  = d[5:0] & 6'h37;
      3'd4: mOff   = d[0];
      default: ;
    endcase
  endtask

  task automatic busRead(logic [2:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData; v = busRdValid;
  endtask

  task automatic checkPads(string tag);
    check({tag, " R2 padOe"}, {2'b0, padOe}, {2'b0, expOe(mDir)});
    check({tag, " R2 padOut"}, {2'b0, padOut & padOe}, {2'b0, mLatch & expOe(mDir)});
    check({tag, " R3 padOe pin3"}, {7'b0, padOe[3]}, 8'h00);
    check({tag, " R7 padPullUp"}, {2'b0, padPullUp}, {2'b0, expPullUp(mOff, mPull, mDir)});
  endtask

  task automatic checkPortRead(string tag);
    logic [7:0] d; logic v;
    repeat (3) @(negedge clk);
    busRead(3'd0, d, v);
    check({tag, " R8 valid"}, {7'b0, v}, 8'h01);
    check({tag, " R4 R5 R6 port read"}, d, expPortRead(padIn, mAna, resetPinEn));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    logic       v;
    void'($urandom(32'h5eed_0b17));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", {2'b0, padOe}, 8'h00);
    check("R1 padPullUp", {2'b0, padPullUp}, 8'h00);
    check("R1 padOut", {2'b0, padOut}, 8'h00);
    check("R1 valid idle", {7'b0, busRdValid}, 8'h00);
    busRead(3'd1, d, v); check("R1 dir", d, 8'h3F);
    busRead(3'd4, d, v); check("R1 ctl", d, 8'h01);
    busRead(3'd3, d, v); check("R9 pull reset", d, 8'h37);
    busRead(3'd2, d, v); check("R9 ana reset", d, 8'h00);
    @(negedge clk);
    check("R8 valid drops", {7'b0, busRdValid}, 8'h00);

    // R3 write zero to all direction bits
    busWrite(3'd1, 8'h00);
    busWrite(3'd0, 8'hFF);
    busRead(3'd1, d, v); check("R3 dir bit3", d, 8'h08);
    checkPads("directed-out");

    // R4 port reads pins, not latch
    padIn = 6'h00;
    checkPortRead("R4 pins low latch high");
    padIn = 6'h2A;
    checkPortRead("R4 pattern");

    // R5 reset pin claims pin 3
    padIn = 6'h3F; resetPinEn = 1'b1;
    checkPortRead("R5 on");
    resetPinEn = 1'b0;
    checkPortRead("R5 off");

    // R6 analog pins read 0 but direction still drives
    busWrite(3'd2, 8'h05);
    checkPortRead("R6 analog");
    checkPads("R6 analog driver");

    // R7 pull-ups enabled, mixed direction
    busWrite(3'd4, 8'h00);
    busWrite(3'd1, 8'h0F);
    checkPads("R7 mixed");
    busWrite(3'd3, 8'hFF);
    busRead(3'd3, d, v); check("R9 pull bit3 zero", d, 8'h37);
    checkPads("R7 all enabled");

    // R8 unmapped offsets, write to unmapped has no effect on mapped
    busWrite(3'd6, 8'hFF);
    for (int a = 5; a < 8; a++) begin
      busRead(3'(a), d, v); check("R8 unmapped", d, 8'h00);
    end
    for (int a = 1; a < 5; a++) begin
      busRead(3'(a), d, v); check("R9 readback", d, expReg(3'(a)));
    end
    checkPads("R8 after unmapped write");

    // Random phase
    for (int it = 0; it < 60; it++) begin
      busWrite(3'($urandom_range(0, 7)), 8'($urandom()));
      busWrite(3'($urandom_range(0, 4)), 8'($urandom()));
      padIn = 6'($urandom());
      resetPinEn = 1'($urandom());
      checkPads("random");
      checkPortRead("random");
      begin
        logic [2:0] ra;
        ra = 3'($urandom_range(1, 7));
        busRead(ra, d, v);
        check("R9 R8 random readback", d, expReg(ra));
      end
    end

    finishRun();
  end

endmodule